// File: doc/BRIEF.md
# Status-Change Interrupt Event Controller

This block watches the status outputs of a timing-source subsystem and turns the transitions that matter into sticky event flags. The status inputs are PLL lock, signal presence, the index of the active reference, the PLL operating mode, external-reference activity and one availability flag per reference. Every input is registered and then compared with its value one cycle earlier. Each qualifying transition sets its own bit in an 8-bit event register, and the bit stays set until software clears it.

An 8-bit enable register decides which recorded events may pull the active-low interrupt line down. An event is recorded whether or not its enable bit is set. Software reaches both registers through a single-cycle strobe bus: `bus_sel` together with `bus_wr`, an 8-bit address, write data and combinational read data. Reading the event register returns its contents and clears every bit at the end of that cycle. An event detected in the same cycle as the clearing read survives the clear, so it is never lost.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset the event register reads 0x00, the enable register reads 0x00 and `irq_n` is high.
- R2: Event bit 7 sets when `lock_in` falls from 1 to 0. A rise of `lock_in` sets no bit. The bit becomes visible after the second rising clock edge following the input change.
- R3: Event bit 6 sets when `sig_ok_in` falls from 1 to 0. A rise of `sig_ok_in` sets no bit.
- R4: Event bit 5 sets whenever `act_ref_in` takes a value different from its previous value. Presenting the same value again sets nothing.
- R5: Event bit 4 sets whenever `pll_mode_in` takes a value different from its previous value. Presenting the same value again sets nothing.
- R6: Event bit 3 sets when `xref_act_in` rises from 0 to 1. Event bit 2 sets when `xref_act_in` falls from 1 to 0.
- R7: Event bit 1 sets when any bit of `ref_avail_in` goes from 0 to 1. Event bit 0 sets when any bit goes from 1 to 0. Both bits set together when some references appear in the same cycle as others disappear.
- R8: An event bit latches regardless of the enable register, and it holds until the event register is read.
- R9: `irq_n` is low exactly when (event AND enable) is nonzero.
- R10: A read at address 0x12 (bus_sel=1, bus_wr=0) returns the event register and clears all of its bits at the following clock edge. `irq_n` then returns high unless a new event arrives.
- R11: When an event is detected in the cycle of a clearing read, the read returns the old contents and the new event bit is set after the clear.
- R12: Address 0x13 is the read/write enable register. A write to 0x12 has no effect. A read of any other address returns 0x00.
- R13: The first two input samples after reset release set no event bits, even when the inputs differ from the reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_in | input | 1 | PLL locked indication |
| sig_ok_in | input | 1 | Input signal present |
| act_ref_in | input | 3 | Index of the active reference |
| pll_mode_in | input | 3 | PLL operating mode code |
| xref_act_in | input | 1 | External reference activity |
| ref_avail_in | input | 8 | Per-reference availability flags |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid during a read strobe |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The hardest situation to reach from the ports is an event landing exactly on the clock edge at which a clearing read takes effect. The bench reaches it by counting register stages. It changes `lock_in` on a falling edge, lets one rising edge load the input register, and then places the read strobe in the next cycle. The read must return the earlier contents, and the loss-of-lock bit must still be present on a second read. The enable gating is swept across all 256 enable values for each single event source, and the mode, reference-index and availability detectors are swept over every value pair or bit position.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

    localparam int NUM_REFS  = 8;
    localparam int REF_IDX_W = $clog2(NUM_REFS);
    localparam int MODE_W    = 3;
    localparam int EVT_W     = 8;
    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 8;
    localparam int PRIME_CNT = 2;
    localparam int PRIME_W   = $clog2(PRIME_CNT + 1);

    localparam logic [ADDR_W-1:0] ADDR_EVENT  = 8'h12;
    localparam logic [ADDR_W-1:0] ADDR_ENABLE = 8'h13;

    // Bit positions of the event register
    localparam int EV_LOCK_LOST = 7;
    localparam int EV_SIG_LOST  = 6;
    localparam int EV_REF_CHG   = 5;
    localparam int EV_MODE_CHG  = 4;
    localparam int EV_XREF_UP   = 3;
    localparam int EV_XREF_DOWN = 2;
    localparam int EV_AVAIL_UP  = 1;
    localparam int EV_AVAIL_DN  = 0;

    typedef struct packed {
        logic                 lock;
        logic                 sig_ok;
        logic [REF_IDX_W-1:0] act_ref;
        logic [MODE_W-1:0]    mode;
        logic                 xref_act;
        logic [NUM_REFS-1:0]  avail;
    } status_t;

    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_READ  = 2'd1,
        BUS_WRITE = 2'd2
    } bus_op_e;

    typedef struct packed {
        bus_op_e op;
        logic    hit_event;
        logic    hit_enable;
    } bus_dec_t;

    function automatic logic fell(input logic prev, input logic cur);
        return prev & ~cur;
    endfunction

    function automatic logic rose(input logic prev, input logic cur);
        return ~prev & cur;
    endfunction

endpackage

// File: rtl/evt_status_sampler.sv
module evt_status_sampler
    import evt_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  status_t          st_in,
    output logic [EVT_W-1:0] det
);
    status_t            cur_q;
    status_t            prev_q;
    logic [PRIME_W-1:0] prime_q;
    logic               primed;
    logic [NUM_REFS-1:0] up_vec;
    logic [NUM_REFS-1:0] dn_vec;
    logic [EVT_W-1:0]   raw;

    assign primed = (prime_q == PRIME_W'(PRIME_CNT));

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q   <= '0;
            prev_q  <= '0;
            prime_q <= '0;
        end else begin
            cur_q  <= st_in;
            prev_q <= cur_q;
            if (!primed)
                prime_q <= prime_q + PRIME_W'(1);
        end
    end

    for (genvar i = 0; i < NUM_REFS; i++) begin : g_ref_edge
        assign up_vec[i] = rose(prev_q.avail[i], cur_q.avail[i]);
        assign dn_vec[i] = fell(prev_q.avail[i], cur_q.avail[i]);
    end

    always_comb begin
        raw               = '0;
        raw[EV_LOCK_LOST] = fell(prev_q.lock, cur_q.lock);
        raw[EV_SIG_LOST]  = fell(prev_q.sig_ok, cur_q.sig_ok);
        raw[EV_REF_CHG]   = (prev_q.act_ref != cur_q.act_ref);
        raw[EV_MODE_CHG]  = (prev_q.mode != cur_q.mode);
        raw[EV_XREF_UP]   = rose(prev_q.xref_act, cur_q.xref_act);
        raw[EV_XREF_DOWN] = fell(prev_q.xref_act, cur_q.xref_act);
        raw[EV_AVAIL_UP]  = |up_vec;
        raw[EV_AVAIL_DN]  = |dn_vec;
    end

    assign det = primed ? raw : '0;

endmodule

// File: rtl/evt_bus_decode.sv
module evt_bus_decode
    import evt_irq_pkg::*;
#(
    parameter logic [ADDR_W-1:0] EVENT_ADDR  = ADDR_EVENT,
    parameter logic [ADDR_W-1:0] ENABLE_ADDR = ADDR_ENABLE
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output bus_dec_t          dec
);
    always_comb begin
        dec.hit_event  = (bus_addr == EVENT_ADDR);
        dec.hit_enable = (bus_addr == ENABLE_ADDR);
        if (!bus_sel)
            dec.op = BUS_IDLE;
        else if (bus_wr)
            dec.op = BUS_WRITE;
        else
            dec.op = BUS_READ;
    end
endmodule

// File: rtl/evt_sticky_reg.sv
module evt_sticky_reg
    import evt_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [EVT_W-1:0] set,
    input  logic             clr_all,
    output logic [EVT_W-1:0] q
);
    for (genvar b = 0; b < EVT_W; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                q[b] <= 1'b0;
            else if (set[b])
                q[b] <= 1'b1;
            else if (clr_all)
                q[b] <= 1'b0;
        end
    end
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
    import evt_irq_pkg::*;
#(
    parameter logic [ADDR_W-1:0] EVENT_ADDR  = ADDR_EVENT,
    parameter logic [ADDR_W-1:0] ENABLE_ADDR = ADDR_ENABLE
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 lock_in,
    input  logic                 sig_ok_in,
    input  logic [REF_IDX_W-1:0] act_ref_in,
    input  logic [MODE_W-1:0]    pll_mode_in,
    input  logic                 xref_act_in,
    input  logic [NUM_REFS-1:0]  ref_avail_in,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 irq_n
);
    status_t          st;
    logic [EVT_W-1:0] det;
    logic [EVT_W-1:0] ev_q;
    logic [EVT_W-1:0] en_q;
    bus_dec_t         dec;
    logic             rd_evt;
    logic             wr_en;

    always_comb begin
        st.lock     = lock_in;
        st.sig_ok   = sig_ok_in;
        st.act_ref  = act_ref_in;
        st.mode     = pll_mode_in;
        st.xref_act = xref_act_in;
        st.avail    = ref_avail_in;
    end

    evt_status_sampler u_sampler (
        .clk   (clk),
        .rst   (rst),
        .st_in (st),
        .det   (det)
    );

    evt_bus_decode #(
        .EVENT_ADDR  (EVENT_ADDR),
        .ENABLE_ADDR (ENABLE_ADDR)
    ) u_dec (
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .dec      (dec)
    );

    assign rd_evt = (dec.op == BUS_READ)  && dec.hit_event;
    assign wr_en  = (dec.op == BUS_WRITE) && dec.hit_enable;

    evt_sticky_reg u_events (
        .clk     (clk),
        .rst     (rst),
        .set     (det),
        .clr_all (rd_evt),
        .q       (ev_q)
    );

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= '0;
        else if (wr_en)
            en_q <= bus_wdata[EVT_W-1:0];
    end

    // Read data reflects the register before any clear at the coming edge
    always_comb begin
        bus_rdata = '0;
        if (dec.op == BUS_READ) begin
            if (dec.hit_event)
                bus_rdata = DATA_W'(ev_q);
            else if (dec.hit_enable)
                bus_rdata = DATA_W'(en_q);
        end
    end

    assign irq_n = ~|(ev_q & en_q);

endmodule

module evt_irq_ctrl_chk
    import evt_irq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [EVT_W-1:0]  det,
    input logic [EVT_W-1:0]  ev_q,
    input logic [EVT_W-1:0]  en_q,
    input logic              rd_evt,
    input logic              wr_en,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              irq_n
);
    AST_SET_ON_DETECT: assert property (@(posedge clk) disable iff (rst)
        (|det) |=> ((ev_q & $past(det)) == $past(det)));                 // R11

    AST_HOLD_UNTIL_READ: assert property (@(posedge clk) disable iff (rst)
        (!rd_evt) |=> ((ev_q & $past(ev_q)) == $past(ev_q)));            // R8

    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (rst)
        (rd_evt && det == '0) |=> (ev_q == '0));                        // R10

    AST_ENABLE_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (en_q == $past(bus_wdata[EVT_W-1:0])));                // R12

    AST_NO_IRQ_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (en_q == '0) |-> irq_n);                                        // R9

    AST_NO_IRQ_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (ev_q == '0) |-> irq_n);                                        // R9
endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .det       (det),
    .ev_q      (ev_q),
    .en_q      (en_q),
    .rd_evt    (rd_evt),
    .wr_en     (wr_en),
    .bus_wdata (bus_wdata),
    .irq_n     (irq_n)
);

// File: tb/evt_irq_ctrl_tb.sv
module evt_irq_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_EVT = 8'h12;
    localparam logic [7:0] A_EN  = 8'h13;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       lock_in = 1'b1, sig_ok_in = 1'b1, xref_act_in = 1'b0;
    logic [2:0] act_ref_in = 3'd0, pll_mode_in = 3'd0;
    logic [7:0] ref_avail_in = 8'hA5;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_irq_ctrl u_dut (
        .clk(clk), .rst(rst), .lock_in(lock_in), .sig_ok_in(sig_ok_in),
        .act_ref_in(act_ref_in), .pll_mode_in(pll_mode_in),
        .xref_act_in(xref_act_in), .ref_avail_in(ref_avail_in),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n)
    );

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic settle_clear();
        logic [7:0] d;
        tick(3);
        bus_read(A_EVT, d);
    endtask

    function automatic string bit_tag(input int b);
        case (b)
            7: return "R2 loss of lock";
            6: return "R3 loss of signal";
            5: return "R4 reference change";
            4: return "R5 mode change";
            3: return "R6 xref up";
            2: return "R6 xref down";
            1: return "R7 avail up";
            default: return "R7 avail down";
        endcase
    endfunction

    // Produce exactly one event of bit b, leaving the register cleared beforehand
    task automatic cause(input int b);
        case (b)
            7: lock_in = 1'b1;
            6: sig_ok_in = 1'b1;
            3: xref_act_in = 1'b0;
            2: xref_act_in = 1'b1;
            1: ref_avail_in = 8'h00;
            0: ref_avail_in = 8'h10;
            default: ;
        endcase
        settle_clear();
        case (b)
            7: lock_in = 1'b0;
            6: sig_ok_in = 1'b0;
            5: act_ref_in = act_ref_in + 3'd1;
            4: pll_mode_in = pll_mode_in + 3'd1;
            3: xref_act_in = 1'b1;
            2: xref_act_in = 1'b0;
            1: ref_avail_in = 8'h40;
            default: ref_avail_in = 8'h00;
        endcase
        tick(3);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        tick(3);
        rst = 1'b0;
        // R1 reset state
        check8("R1 irq_n after reset", {7'd0, irq_n}, 8'h01);
        bus_read(A_EN, d);
        check8("R1 enable reset", d, 8'h00);
        // R13 inputs differ from reset values, yet no events appear
        tick(4);
        bus_read(A_EVT, d);
        check8("R13 no events from priming", d, 8'h00);
        check8("R1 irq_n idle", {7'd0, irq_n}, 8'h01);

        // R12 enable register read/write, write to event address ignored
        bus_write(A_EN, 8'h5A);
        bus_read(A_EN, d);
        check8("R12 enable readback", d, 8'h5A);
        bus_write(A_EVT, 8'hFF);
        bus_read(A_EVT, d);
        check8("R12 event write ignored", d, 8'h00);
        bus_read(8'h40, d);
        check8("R12 unmapped read", d, 8'h00);
        bus_write(A_EN, 8'h00);

        // R2 latency: visible only after the second edge
        lock_in = 1'b1; settle_clear();
        lock_in = 1'b0;
        tick(1);
        bus_read(A_EVT, d);
        check8("R11 read after one edge", d, 8'h00);
        tick(1);
        bus_read(A_EVT, d);
        check8("R2 loss of lock latency", d, 8'h80);

        // R2 R3 rises set nothing
        lock_in = 1'b0; sig_ok_in = 1'b0; settle_clear();
        lock_in = 1'b1; sig_ok_in = 1'b1; tick(3);
        bus_read(A_EVT, d);
        check8("R2 R3 rising edges ignored", d, 8'h00);

        // R6 activity toggle both ways
        xref_act_in = 1'b0; settle_clear();
        xref_act_in = 1'b1; tick(3);
        xref_act_in = 1'b0; tick(3);
        bus_read(A_EVT, d);
        check8("R6 both xref edges", d, 8'h0C);

        // R4 R5 all value pairs
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                pll_mode_in = 3'(a); act_ref_in = 3'(b); settle_clear();
                pll_mode_in = 3'(b); act_ref_in = 3'(a); tick(3);
                bus_read(A_EVT, d);
                check8("R4 R5 value pair", d, (a == b) ? 8'h00 : 8'h30);
            end
        end

        // R7 single-bit sweeps and the simultaneous case
        for (int i = 0; i < 8; i++) begin
            ref_avail_in = 8'h00; settle_clear();
            ref_avail_in = 8'(1 << i); tick(3);
            bus_read(A_EVT, d);
            check8("R7 one reference up", d, 8'h02);
            ref_avail_in = 8'h00; tick(3);
            bus_read(A_EVT, d);
            check8("R7 one reference down", d, 8'h01);
        end
        ref_avail_in = 8'h0F; settle_clear();
        ref_avail_in = 8'hF0; tick(3);
        bus_read(A_EVT, d);
        check8("R7 up and down together", d, 8'h03);

        // R8 R9 R10 enable sweep for each event source
        for (int b = 0; b < 8; b++) begin
            bus_write(A_EN, 8'h00);
            cause(b);
            check8("R8 disabled event no irq", {7'd0, irq_n}, 8'h01);
            for (int e = 0; e < 256; e++) begin
                bus_write(A_EN, 8'(e));
                check8("R9 irq gating", {7'd0, irq_n}, {7'd0, ((e >> b) & 1) == 0});
            end
            bus_write(A_EN, 8'hFF);
            bus_read(A_EVT, d);
            check8(bit_tag(b), d, 8'(1 << b));
            check8("R10 irq released after read", {7'd0, irq_n}, 8'h01);
            bus_read(A_EVT, d);
            check8("R10 cleared", d, 8'h00);
        end

        // R11 event on the clearing edge
        bus_write(A_EN, 8'h00);
        xref_act_in = 1'b0; lock_in = 1'b1; settle_clear();
        xref_act_in = 1'b1; tick(3);
        lock_in = 1'b0;
        tick(1);
        bus_read(A_EVT, d);
        check8("R11 read returns old contents", d, 8'h08);
        bus_read(A_EVT, d);
        check8("R11 new event survives clear", d, 8'h80);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule